// File: doc/BRIEF.md
# SECDED Hamming Decoder

A purely combinational decoder for extended Hamming codewords. It takes a received word made of an inner positional Hamming codeword plus one overall parity bit, and returns the information vector with any single-bit error removed. It also returns the syndrome and three mutually exclusive status flags: clean word, single error corrected, and uncorrectable error.

The information width is a parameter. The number of check bits is derived from it at elaboration. A second parameter chooses whether the overall parity bit is the lowest or the highest bit of the received word. The decoder is meant to sit directly behind a storage array or link whose words were protected by the matching extended Hamming encoding. The caller registers the outputs where timing requires it.

Top module: `secded_dec`

## Requirements
- R1: With DATA_W information bits, the check width CHK_W is the smallest m with 2^m >= m + DATA_W + 1. The inner codeword spans positions 1..CW_W with CW_W = CHK_W + DATA_W, and `word_i` is CW_W+1 bits wide (13 bits for DATA_W=8, 10 bits for DATA_W=5).
- R2: Check bit i (1..CHK_W) sits at inner position 2^(i-1). Information bits fill the positions that are not powers of two in rising order, starting with information bit 0. When PAR_AT_LSB=1, the overall parity bit is `word_i[0]` and inner position p is `word_i[p]`. When PAR_AT_LSB=0, the overall parity bit is `word_i[CW_W]` and inner position p is `word_i[p-1]`.
- R3: `syndrome_o` bit b is the XOR of every received inner position whose index has bit b set, including the check bit itself. A valid codeword gives zero. A single flipped inner bit gives its position.
- R4: A zero syndrome with even overall parity (XOR of all received bits) raises only `ok_o`, and `data_o` is the encoded information.
- R5: Odd overall parity with a syndrome in 1..CW_W raises only `corr_o`, and `data_o` is read after inverting the inner bit at the syndrome position.
- R6: Odd overall parity with a zero syndrome (only the overall parity bit was hit) raises only `corr_o`, and `data_o` is the information bits as received.
- R7: A nonzero syndrome with even overall parity raises only `uncorr_o`, and `data_o` is the information bits as received, with nothing inverted.
- R8: Odd overall parity with a syndrome above CW_W raises only `uncorr_o`, and `data_o` is the information bits as received.
- R9: Exactly one of `ok_o`, `corr_o` and `uncorr_o` is high for every input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| word_i | input | CW_W+1 | Received codeword including the overall parity bit |
| data_o | output | DATA_W | Information vector after correction |
| syndrome_o | output | CHK_W | Hamming syndrome of the inner codeword |
| ok_o | output | 1 | No error found |
| corr_o | output | 1 | Single error found and corrected |
| uncorr_o | output | 1 | Error found that cannot be corrected |

## Verification
The block holds no state, so a fault in the syndrome tree, the range compare or the correction mask shows at the ports in the same evaluation as the input word that exposes it. A wrong syndrome bit moves the correction to the wrong data bit, or changes the status class, on the first single flip that covers that bit. A wrong range compare shows only on odd-weight errors whose syndrome points past the last position. The sweeps therefore include every single flip, all pairs over sample data, and triple flips, which are the only way to reach those out-of-range syndromes.

// File: rtl/secded_pkg.sv
package secded_pkg;

  function automatic int calc_chk_w(input int k);
    int m;
    m = 1;
    while ((1 << m) < m + k + 1) m++;
    return m;
  endfunction

  function automatic bit is_pow2(input int p);
    return (p > 0) && ((p & (p - 1)) == 0);
  endfunction

  // inner position of information bit j
  function automatic int data_pos(input int j);
    int p;
    int c;
    p = 2;
    c = -1;
    while (c < j) begin
      p++;
      if (!is_pow2(p)) c++;
    end
    return p;
  endfunction

endpackage

// File: rtl/secded_split.sv
module secded_split
  import secded_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit PAR_AT_LSB = 1'b1,
  localparam int CHK_W     = calc_chk_w(DATA_W),
  localparam int CW_W      = CHK_W + DATA_W
) (
  input  logic [CW_W:0]     word_i,
  output logic [CW_W:1]     inner_o,
  output logic              ext_o,
  output logic [DATA_W-1:0] raw_o
);

  if (PAR_AT_LSB) begin : g_lsb
    assign inner_o = word_i[CW_W:1];
    assign ext_o   = word_i[0];
  end else begin : g_msb
    assign inner_o = word_i[CW_W-1:0];
    assign ext_o   = word_i[CW_W];
  end

  for (genvar g = 0; g < DATA_W; g++) begin : g_raw
    assign raw_o[g] = inner_o[data_pos(g)];
  end

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHK_W = calc_chk_w(DATA_W),
  localparam int CW_W  = CHK_W + DATA_W
) (
  input  logic [CW_W:1]    inner_i,
  input  logic             ext_i,
  output logic [CHK_W-1:0] syn_o,
  output logic             odd_o
);

  function automatic logic cover_xor(input logic [CW_W:1] v, input int b);
    logic acc;
    acc = 1'b0;
    for (int p = 1; p <= CW_W; p++)
      if (((p >> b) & 1) == 1) acc ^= v[p];
    return acc;
  endfunction

  for (genvar g = 0; g < CHK_W; g++) begin : g_chk
    assign syn_o[g] = cover_xor(inner_i, g);
  end

  assign odd_o = (^inner_i) ^ ext_i;

endmodule

// File: rtl/secded_classify.sv
module secded_classify
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHK_W = calc_chk_w(DATA_W),
  localparam int CW_W  = CHK_W + DATA_W
) (
  input  logic [CHK_W-1:0] syn_i,
  input  logic             odd_i,
  output logic             ok_o,
  output logic             corr_o,
  output logic             uncorr_o,
  output logic             fix_en_o
);

  localparam logic [CHK_W-1:0] LAST_POS = CHK_W'(CW_W);

  logic syn_nz;
  logic in_range;

  assign syn_nz   = |syn_i;
  assign in_range = (syn_i <= LAST_POS);

  assign ok_o     = !syn_nz && !odd_i;
  assign corr_o   = odd_i && (!syn_nz || in_range);
  assign uncorr_o = syn_nz && (!odd_i || !in_range);
  assign fix_en_o = odd_i && syn_nz && in_range;

endmodule

// File: rtl/secded_fix.sv
module secded_fix
  import secded_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CHK_W = calc_chk_w(DATA_W)
) (
  input  logic [DATA_W-1:0] raw_i,
  input  logic [CHK_W-1:0]  syn_i,
  input  logic              fix_en_i,
  output logic [DATA_W-1:0] data_o
);

  // check-bit hits need no data fix, so only data positions are decoded
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    localparam logic [CHK_W-1:0] POS = CHK_W'(data_pos(g));
    assign data_o[g] = raw_i[g] ^ (fix_en_i && (syn_i == POS));
  end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import secded_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit PAR_AT_LSB = 1'b1,
  localparam int CHK_W     = calc_chk_w(DATA_W),
  localparam int CW_W      = CHK_W + DATA_W
) (
  input  logic [CW_W:0]     word_i,
  output logic [DATA_W-1:0] data_o,
  output logic [CHK_W-1:0]  syndrome_o,
  output logic              ok_o,
  output logic              corr_o,
  output logic              uncorr_o
);

  logic [CW_W:1]     inner;
  logic              ext;
  logic [DATA_W-1:0] raw;
  logic              odd;
  logic              fix_en;

  secded_split #(.DATA_W(DATA_W), .PAR_AT_LSB(PAR_AT_LSB)) u_split (
    .word_i (word_i),
    .inner_o(inner),
    .ext_o  (ext),
    .raw_o  (raw)
  );

  secded_syndrome #(.DATA_W(DATA_W)) u_syn (
    .inner_i(inner),
    .ext_i  (ext),
    .syn_o  (syndrome_o),
    .odd_o  (odd)
  );

  secded_classify #(.DATA_W(DATA_W)) u_cls (
    .syn_i   (syndrome_o),
    .odd_i   (odd),
    .ok_o    (ok_o),
    .corr_o  (corr_o),
    .uncorr_o(uncorr_o),
    .fix_en_o(fix_en)
  );

  secded_fix #(.DATA_W(DATA_W)) u_fix (
    .raw_i   (raw),
    .syn_i   (syndrome_o),
    .fix_en_i(fix_en),
    .data_o  (data_o)
  );

endmodule

// File: rtl/secded_dec_chk.sv
module secded_dec_chk
  import secded_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter bit PAR_AT_LSB = 1'b1,
  localparam int CHK_W     = calc_chk_w(DATA_W),
  localparam int CW_W      = CHK_W + DATA_W
) (
  input logic [CW_W:0]     word_i,
  input logic [DATA_W-1:0] data_o,
  input logic [CHK_W-1:0]  syndrome_o,
  input logic              ok_o,
  input logic              corr_o,
  input logic              uncorr_o
);

  function automatic logic [CW_W:0] reencode(input logic [DATA_W-1:0] d);
    logic [CW_W:1] v;
    logic acc;
    v = '0;
    for (int j = 0; j < DATA_W; j++) v[data_pos(j)] = d[j];
    for (int b = 0; b < CHK_W; b++) begin
      acc = 1'b0;
      for (int p = 1; p <= CW_W; p++)
        if (((p >> b) & 1) == 1) acc ^= v[p];
      v[1 << b] = acc;
    end
    return PAR_AT_LSB ? {v, ^v} : {^v, v};
  endfunction

  function automatic logic [DATA_W-1:0] as_received(input logic [CW_W:0] w);
    logic [CW_W:1] v;
    logic [DATA_W-1:0] d;
    v = PAR_AT_LSB ? w[CW_W:1] : w[CW_W-1:0];
    for (int j = 0; j < DATA_W; j++) d[j] = v[data_pos(j)];
    return d;
  endfunction

  always_comb begin
    a_r9_one_flag: assert ($onehot({ok_o, corr_o, uncorr_o}));
    a_r4_clean_word: assert (!ok_o || (reencode(data_o) == word_i && syndrome_o == '0));
    a_r5_one_flip: assert (!corr_o || $countones(reencode(data_o) ^ word_i) == 1);
    a_r6_ext_only: assert (!(corr_o && syndrome_o == '0) || data_o == as_received(word_i));
    a_r7_no_alter: assert (!uncorr_o || data_o == as_received(word_i));
  end

endmodule

bind secded_dec secded_dec_chk #(.DATA_W(DATA_W), .PAR_AT_LSB(PAR_AT_LSB)) u_chk (
  .word_i    (word_i),
  .data_o    (data_o),
  .syndrome_o(syndrome_o),
  .ok_o      (ok_o),
  .corr_o    (corr_o),
  .uncorr_o  (uncorr_o)
);

// File: tb/sim_secded_unit.sv
module sim_secded_unit #(
  parameter int K = 8,
  parameter bit P = 1'b1
) (
  input  logic clk_i,
  output logic done_o,
  output int   checks_o,
  output int   fails_o
);

  function automatic int m_of(input int k);
    int m;
    m = 1;
    while ((1 << m) < m + k + 1) m++;
    return m;
  endfunction

  localparam int M = m_of(K);
  localparam int N = M + K;

  logic [N:0]   word;
  logic [K-1:0] data;
  logic [M-1:0] syn;
  logic         ok, corr, uncorr;

  secded_dec #(.DATA_W(K), .PAR_AT_LSB(P)) u0 (
    .word_i    (word),
    .data_o    (data),
    .syndrome_o(syn),
    .ok_o      (ok),
    .corr_o    (corr),
    .uncorr_o  (uncorr)
  );

  function automatic int bit_of(input int pos);
    if (P) return pos;
    return (pos == 0) ? N : pos - 1;
  endfunction

  function automatic logic [N:0] encode(input logic [K-1:0] d);
    logic [N:0] w;
    logic [N:1] iv;
    logic s;
    int j;
    iv = '0;
    j = 0;
    for (int p = 1; p <= N; p++)
      if ((p & (p - 1)) != 0) begin
        iv[p] = d[j];
        j++;
      end
    for (int b = 0; b < M; b++) begin
      s = 1'b0;
      for (int p = 1; p <= N; p++) if (p[b]) s ^= iv[p];
      iv[1 << b] = s;
    end
    w = '0;
    for (int p = 1; p <= N; p++) w[bit_of(p)] = iv[p];
    w[bit_of(0)] = ^iv;
    return w;
  endfunction

  function automatic logic [K-1:0] extract(input logic [N:0] w);
    logic [K-1:0] d;
    int j;
    j = 0;
    d = '0;
    for (int p = 1; p <= N; p++)
      if ((p & (p - 1)) != 0) begin
        d[j] = w[bit_of(p)];
        j++;
      end
    return d;
  endfunction

  task automatic check(input bit good, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks_o++;
    if (!good) begin
      fails_o++;
      $display("FAIL %s K=%0d P=%0d word=%h act=%h exp=%h", req, K, P, word, act, exp);
    end
  endtask

  // n flips at inner positions a,b,c (0 = overall parity bit)
  task automatic run(input logic [K-1:0] d, input int n, input int a, input int b, input int c);
    logic [N:0] w;
    int f[3];
    int s;
    bit odd;
    logic [2:0] ef;
    logic [K-1:0] ed;
    string tag;
    f[0] = a; f[1] = b; f[2] = c;
    w = encode(d);
    s = 0;
    for (int i = 0; i < n; i++) begin
      w[bit_of(f[i])] ^= 1'b1;
      s ^= f[i];
    end
    odd = n[0];
    if (n == 0) begin ef = 3'b100; tag = "R4"; end
    else if (odd && s <= N) begin ef = 3'b010; tag = (n == 1) ? ((s == 0) ? "R6" : "R5") : "R5"; end
    else begin ef = 3'b001; tag = (n == 2) ? "R7" : "R8"; end
    if (n <= 1) ed = d;
    else if (ef == 3'b010 && s != 0) begin
      logic [N:0] t;
      t = w;
      t[bit_of(s)] ^= 1'b1;
      ed = extract(t);
    end else ed = extract(w);
    @(posedge clk_i);
    #1 word = w;
    @(negedge clk_i);
    check({data, ok, corr, uncorr} == {ed, ef}, tag, 32'({data, ok, corr, uncorr}), 32'({ed, ef}));
    check(syn == M'(s), "R3", 32'(syn), 32'(s));
    check($onehot({ok, corr, uncorr}), "R9", 32'({ok, corr, uncorr}), 32'(ef));
  endtask

  initial begin
    done_o   = 1'b0;
    checks_o = 0;
    fails_o  = 0;
    word     = '0;
    // R1: port widths
    check($bits(word) == N + 1 && $bits(syn) == M, "R1", 32'($bits(syn)), 32'(M));
    // all-zero word is a clean codeword (R2 layout, R4)
    run('0, 0, 0, 0, 0);
    for (int i = 0; i < (1 << K); i++) begin
      logic [K-1:0] d = i[K-1:0];
      run(d, 0, 0, 0, 0);
      for (int f = 0; f <= N; f++) run(d, 1, f, 0, 0);
    end
    for (int i = 0; i < 16; i++) begin
      logic [K-1:0] d = K'((i * 37 + 5) % (1 << K));
      for (int a = 0; a <= N; a++)
        for (int b = a + 1; b <= N; b++) run(d, 2, a, b, 0);
    end
    for (int i = 0; i < 4; i++) begin
      logic [K-1:0] d = K'((i * 91 + 3) % (1 << K));
      for (int a = 0; a <= N; a++)
        for (int b = a + 1; b <= N; b++)
          for (int c = b + 1; c <= N; c++) run(d, 3, a, b, c);
    end
    done_o = 1'b1;
  end

endmodule

// File: tb/sim_secded_dec.sv
module sim_secded_dec;

  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic d0, d1, d2, d3;
  int   c0, c1, c2, c3;
  int   f0, f1, f2, f3;

  sim_secded_unit #(.K(8), .P(1'b1)) u_k8_lsb (.clk_i(clk), .done_o(d0), .checks_o(c0), .fails_o(f0));
  sim_secded_unit #(.K(8), .P(1'b0)) u_k8_msb (.clk_i(clk), .done_o(d1), .checks_o(c1), .fails_o(f1));
  sim_secded_unit #(.K(5), .P(1'b1)) u_k5_lsb (.clk_i(clk), .done_o(d2), .checks_o(c2), .fails_o(f2));
  sim_secded_unit #(.K(5), .P(1'b0)) u_k5_msb (.clk_i(clk), .done_o(d3), .checks_o(c3), .fails_o(f3));

  initial begin
    int cyc;
    int total;
    int bad;
    cyc = 0;
    while (!(d0 && d1 && d2 && d3) && cyc < LIMIT) begin
      @(posedge clk);
      cyc++;
    end
    total = c0 + c1 + c2 + c3;
    bad   = f0 + f1 + f2 + f3;
    if (!(d0 && d1 && d2 && d3)) begin
      total++;
      bad++;
      $display("FAIL watchdog after %0d cycles act=running exp=done", cyc);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule